// File: doc/BRIEF.md
# Geometry command queue with status register

This block sits between a host bus and the command executor of a 3D geometry engine. A write into the command port window becomes one queue entry. The command code comes from the write address rather than from the data. The write data supplies the parameter bytes. Codes that carry no execution cost are never queued. Writes that arrive while the queue is full are lost.

The executor reads the oldest entry through a valid/pop pair. It also reports back three things: when it is busy, when a buffer swap is pending, and when a matrix-stack error has occurred. The block turns this state into one 32-bit status word, which is always visible on `status_o`. From the same state it produces a level interrupt request, following a two-bit mode field that the host writes.

Address map, using a 10-bit byte offset:
- Offsets with bit 9 clear are command ports, and the code is offset bits [8:2].
- Offset 0x200 is the lower status half.
- Offset 0x202 is the upper status half.

Top module: `geo_cmd_queue`

## Requirements
- R1: A write with `wr_addr_i[9]`=0 and a costed code `wr_addr_i[8:2]` enqueues that code. The parameter is `wr_data_i` for a 32-bit write (`wr_wide_i`=1) and `{16'h0, wr_data_i[15:0]}` for a 16-bit write. Entries leave in arrival order on `cmd_o`/`param_o` while `valid_o`=1.
- R2: Only codes 0x10–0x1C, 0x20–0x2B, 0x30–0x34, 0x40, 0x41, 0x50, 0x60 and 0x70–0x72 carry a cost. A command-port write with any other code leaves the queue unchanged.
- R3: The queue holds 256 entries. A command write while 256 entries are held is dropped, and the count stays at 256.
- R4: The status word holds the reported count in bits [24:16]. The reported count is the occupancy plus 1 while a swap is pending. Bit 25 is set when the reported count is below 128, and bit 26 is set when it is 0. After reset the status word is 0x0600_0000.
- R5: A push and a pop in the same cycle leave the count unchanged, and the entry that was at the head is the one consumed. A pop while the queue is empty has no effect.
- R6: The interrupt mode is held in bits [31:30]. In mode 1, `irq_o` is high while bit 25 is set. In mode 2, it is high while bit 26 is set. In modes 0 and 3 it stays low. The output is a level.
- R7: A write to the upper status half changes only the mode bits. The mode is taken from `wr_data_i[15:14]` for a 16-bit write at 0x202 and from `wr_data_i[31:30]` for a 32-bit write at 0x200. Every other status field is unaffected.
- R8: Status bit 27 (busy) is set while a swap is pending, or one cycle after `exec_busy_i` is high.
- R9: `stk_err_set_i` sets the sticky error bit 1, and `proj_lvl_set_i` sets the projection level bit 0. A lower-half write with data bit 1 = 1 clears both bits, and a set in the same cycle wins. A lower-half write with bit 1 = 0 leaves both bits unchanged.
- R10: `swap_req_i` makes a swap pending and `swap_ack_i` ends it, with the acknowledge winning if both arrive together. A pending swap does not raise `valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Bus write strobe |
| wr_addr_i | input | 10 | Byte offset of the write |
| wr_wide_i | input | 1 | 1 for a 32-bit write, 0 for a 16-bit write |
| wr_data_i | input | 32 | Write data |
| pop_i | input | 1 | Executor consumes the head entry |
| valid_o | output | 1 | Queue holds at least one entry |
| cmd_o | output | 7 | Head command code |
| param_o | output | 32 | Head parameter bytes |
| exec_busy_i | input | 1 | Executor is running a command |
| swap_req_i | input | 1 | Start of a pending buffer swap |
| swap_ack_i | input | 1 | End of the pending buffer swap |
| stk_err_set_i | input | 1 | Matrix-stack error event |
| proj_lvl_set_i | input | 1 | Projection stack level becomes 1 |
| status_o | output | 32 | Status word |
| irq_o | output | 1 | Interrupt request level |

## Verification
A wrong occupancy count shows in `status_o[24:16]` on the cycle after the write or pop that caused it. A wrong count also moves the half and empty flags and, through them, `irq_o`. A wrong pointer shows up as a mismatch between the head entry and the scoreboard at the next pop. A swap or error flag that is held wrongly shows in the status word one cycle after its event or its clearing write.

// File: rtl/geo_cmd_pkg.sv
package geo_cmd_pkg;
  localparam int CMD_W   = 7;
  localparam int PARAM_W = 32;

  // status word bit positions
  localparam int ST_PROJ  = 0;
  localparam int ST_ERR   = 1;
  localparam int ST_CNT   = 16;
  localparam int ST_CNT_W = 9;
  localparam int ST_HALF  = 25;
  localparam int ST_EMPTY = 26;
  localparam int ST_BUSY  = 27;
  localparam int ST_MODE  = 30;

  typedef enum logic [1:0] {
    IRQ_OFF   = 2'd0,
    IRQ_HALF  = 2'd1,
    IRQ_EMPTY = 2'd2,
    IRQ_RSVD  = 2'd3
  } irq_mode_e;

  typedef struct packed {
    logic [CMD_W-1:0]   code;
    logic [PARAM_W-1:0] param;
  } cmd_entry_t;

  localparam int ENTRY_W = $bits(cmd_entry_t);

  function automatic logic cmd_has_cost(input logic [CMD_W-1:0] c);
    return (c >= 7'h10 && c <= 7'h1C) || (c >= 7'h20 && c <= 7'h2B) ||
           (c >= 7'h30 && c <= 7'h34) || (c == 7'h40) || (c == 7'h41) ||
           (c == 7'h50) || (c == 7'h60) || (c >= 7'h70 && c <= 7'h72);
  endfunction
endpackage

// File: rtl/geo_cmd_decode.sv
module geo_cmd_decode
  import geo_cmd_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic               wr_wide_i,
  input  logic [31:0]        wr_data_i,
  output logic               push_o,
  output cmd_entry_t         push_entry_o,
  output logic               mode_we_o,
  output logic [1:0]         mode_o,
  output logic               err_clr_o
);
  logic             cmd_hit, st_hit;
  logic [CMD_W-1:0] code;
  logic [15:0]      upper_data;

  assign code    = wr_addr_i[8:2];
  assign cmd_hit = wr_en_i && !wr_addr_i[ADDR_W-1];
  assign st_hit  = wr_en_i && wr_addr_i[ADDR_W-1] && (wr_addr_i[ADDR_W-2:2] == '0);

  always_comb begin
    push_o             = cmd_hit && cmd_has_cost(code);
    push_entry_o.code  = code;
    push_entry_o.param = wr_wide_i ? wr_data_i : {16'h0, wr_data_i[15:0]};
  end

  // a 32-bit write at the lower half covers both halves
  assign upper_data = wr_wide_i ? wr_data_i[31:16] : wr_data_i[15:0];
  assign mode_we_o  = st_hit && (wr_addr_i[1] || wr_wide_i);
  assign mode_o     = upper_data[15:14];
  assign err_clr_o  = st_hit && !wr_addr_i[1] && wr_data_i[ST_ERR];
endmodule

// File: rtl/geo_cmd_fifo.sv
module geo_cmd_fifo
  import geo_cmd_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  cmd_entry_t       push_entry_i,
  input  logic             pop_i,
  output cmd_entry_t       head_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]   wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               push_ok, pop_ok;

  assign push_ok = push_i && (cnt_q < CNT_W'(DEPTH));
  assign pop_ok  = pop_i && (cnt_q != '0);

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_ok)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) mem[wr_ptr_q] <= push_entry_i;
  end

  assign head_o = cmd_entry_t'(mem[rd_ptr_q]);
  assign cnt_o  = cnt_q;

  AST_FULL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_W'(DEPTH)) && !pop_i |=> cnt_q == CNT_W'(DEPTH)); // R3
  AST_PUSH_POP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_ok && pop_ok |=> $stable(cnt_q)); // R5
  AST_POP_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0) && !push_i |=> cnt_q == '0); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH)); // R3
endmodule

// File: rtl/geo_cmd_status.sv
module geo_cmd_status
  import geo_cmd_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int CNT_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] occ_i,
  input  logic             mode_we_i,
  input  logic [1:0]       mode_i,
  input  logic             err_clr_i,
  input  logic             stk_err_set_i,
  input  logic             proj_lvl_set_i,
  input  logic             exec_busy_i,
  input  logic             swap_req_i,
  input  logic             swap_ack_i,
  output logic [31:0]      status_o,
  output logic             irq_o
);
  localparam int HALF = DEPTH / 2;

  irq_mode_e        mode_q;
  logic             err_q, proj_q, swap_q, busy_q;
  logic [CNT_W-1:0] rep_cnt;
  logic             below_half, is_empty;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= IRQ_OFF;
      err_q  <= 1'b0;
      proj_q <= 1'b0;
      swap_q <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      if (mode_we_i) mode_q <= irq_mode_e'(mode_i);
      if (stk_err_set_i)  err_q <= 1'b1;
      else if (err_clr_i) err_q <= 1'b0;
      if (proj_lvl_set_i) proj_q <= 1'b1;
      else if (err_clr_i) proj_q <= 1'b0;
      if (swap_ack_i)      swap_q <= 1'b0;
      else if (swap_req_i) swap_q <= 1'b1;
      busy_q <= exec_busy_i;
    end
  end

  assign rep_cnt    = occ_i + CNT_W'(swap_q);
  assign below_half = rep_cnt < CNT_W'(HALF);
  assign is_empty   = rep_cnt == '0;

  always_comb begin
    status_o                   = '0;
    status_o[ST_PROJ]          = proj_q;
    status_o[ST_ERR]           = err_q;
    status_o[ST_CNT +: ST_CNT_W] = ST_CNT_W'(rep_cnt);
    status_o[ST_HALF]          = below_half;
    status_o[ST_EMPTY]         = is_empty;
    status_o[ST_BUSY]          = busy_q || swap_q;
    status_o[ST_MODE +: 2]     = mode_q;
  end

  always_comb begin
    unique case (mode_q)
      IRQ_HALF:  irq_o = below_half;
      IRQ_EMPTY: irq_o = is_empty;
      default:   irq_o = 1'b0;
    endcase
  end

  AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[ST_MODE +: 2] == 2'd0 || status_o[ST_MODE +: 2] == 2'd3) |-> !irq_o); // R6
  AST_ERR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_clr_i && !stk_err_set_i |=> !status_o[ST_ERR]); // R9
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[ST_ERR] && !err_clr_i |=> status_o[ST_ERR]); // R9
  AST_SWAP_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swap_req_i && !swap_ack_i |=> status_o[ST_BUSY] && !status_o[ST_EMPTY]); // R8
  AST_EXEC_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_busy_i |=> status_o[ST_BUSY]); // R8
endmodule

// File: rtl/geo_cmd_queue.sv
module geo_cmd_queue
  import geo_cmd_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DEPTH  = 256,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic              wr_wide_i,
  input  logic [31:0]       wr_data_i,
  input  logic              pop_i,
  output logic              valid_o,
  output logic [CMD_W-1:0]  cmd_o,
  output logic [31:0]       param_o,
  input  logic              exec_busy_i,
  input  logic              swap_req_i,
  input  logic              swap_ack_i,
  input  logic              stk_err_set_i,
  input  logic              proj_lvl_set_i,
  output logic [31:0]       status_o,
  output logic              irq_o
);
  logic             push, mode_we, err_clr;
  logic [1:0]       mode;
  cmd_entry_t       push_entry, head;
  logic [CNT_W-1:0] occ;

  geo_cmd_decode #(.ADDR_W(ADDR_W)) u_decode (
    .wr_en_i      (wr_en_i),
    .wr_addr_i    (wr_addr_i),
    .wr_wide_i    (wr_wide_i),
    .wr_data_i    (wr_data_i),
    .push_o       (push),
    .push_entry_o (push_entry),
    .mode_we_o    (mode_we),
    .mode_o       (mode),
    .err_clr_o    (err_clr)
  );

  geo_cmd_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .push_i       (push),
    .push_entry_i (push_entry),
    .pop_i        (pop_i),
    .head_o       (head),
    .cnt_o        (occ)
  );

  geo_cmd_status #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_status (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .occ_i          (occ),
    .mode_we_i      (mode_we),
    .mode_i         (mode),
    .err_clr_i      (err_clr),
    .stk_err_set_i  (stk_err_set_i),
    .proj_lvl_set_i (proj_lvl_set_i),
    .exec_busy_i    (exec_busy_i),
    .swap_req_i     (swap_req_i),
    .swap_ack_i     (swap_ack_i),
    .status_o       (status_o),
    .irq_o          (irq_o)
  );

  assign valid_o = occ != '0;
  assign cmd_o   = head.code;
  assign param_o = head.param;

  AST_UNCOSTED_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !wr_addr_i[ADDR_W-1] && !cmd_has_cost(wr_addr_i[8:2]) && !pop_i
    |=> $stable(occ)); // R2
  AST_VALID_OCC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> status_o[ST_CNT +: ST_CNT_W] != '0); // R10
endmodule

// File: tb/geo_cmd_queue_tb_top.sv
module geo_cmd_queue_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 0, wr_wide = 0, pop = 0;
  logic [9:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        exec_busy = 0, swap_req = 0, swap_ack = 0, err_set = 0, proj_set = 0;
  logic        valid, irq;
  logic [6:0]  cmd;
  logic [31:0] param, status;

  int n_chk = 0, n_fail = 0;
  logic [38:0] sb[$];
  logic [1:0]  m_mode = 0;
  logic        m_err = 0, m_proj = 0, m_swap = 0, m_busy = 0;

  always #2 clk = ~clk;

  geo_cmd_queue dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_wide_i(wr_wide), .wr_data_i(wr_data), .pop_i(pop), .valid_o(valid),
    .cmd_o(cmd), .param_o(param), .exec_busy_i(exec_busy), .swap_req_i(swap_req),
    .swap_ack_i(swap_ack), .stk_err_set_i(err_set), .proj_lvl_set_i(proj_set),
    .status_o(status), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [38:0] act, input logic [38:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic costed(input logic [6:0] c);
    if (c inside {[7'h10:7'h1C], [7'h20:7'h2B], [7'h30:7'h34], 7'h40, 7'h41,
                  7'h50, 7'h60, [7'h70:7'h72]}) return 1'b1;
    return 1'b0;
  endfunction

  function automatic int rep();
    return sb.size() + int'(m_swap);
  endfunction

  function automatic logic [31:0] exp_status();
    logic [31:0] s = '0;
    s[0] = m_proj; s[1] = m_err;
    s[24:16] = 9'(rep());
    s[25] = rep() < 128; s[26] = rep() == 0;
    s[27] = m_busy || m_swap;
    s[31:30] = m_mode;
    return s;
  endfunction

  function automatic logic exp_irq();
    return (m_mode == 2'd1 && rep() < 128) || (m_mode == 2'd2 && rep() == 0);
  endfunction

  task automatic bus_wr(input logic [9:0] a, input logic wide, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_wide = wide; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  // driver: command write plus scoreboard update
  task automatic cmd_wr(input logic [6:0] c, input logic wide, input logic [31:0] d);
    if (costed(c) && sb.size() < 256)
      sb.push_back({c, wide ? d : {16'h0, d[15:0]}});
    bus_wr({1'b0, c, 2'b00}, wide, d);
  endtask

  // monitor: compare head with scoreboard, then consume it
  task automatic pop_chk(input string req);
    logic [38:0] e;
    @(negedge clk);
    e = sb.pop_front();
    chk(req, {valid, cmd, param}, {1'b1, e});
    pop = 1;
    @(negedge clk);
    pop = 0;
  endtask

  task automatic chk_st(input string req);
    chk(req, {7'h0, status}, {7'h0, exp_status()});
    chk(req, {38'h0, irq}, {38'h0, exp_irq()});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R4 reset", {7'h0, status}, {7'h0, 32'h0600_0000});
    chk("R4 reset valid", {38'h0, valid}, 39'h0);

    // R1 widths and order
    cmd_wr(7'h10, 0, 32'hABCD_1234);
    cmd_wr(7'h20, 1, 32'hDEAD_BEEF);
    chk_st("R4 two entries");
    // R2 uncosted codes
    cmd_wr(7'h00, 1, 32'h1);
    cmd_wr(7'h1D, 0, 32'h2);
    cmd_wr(7'h7F, 1, 32'h3);
    chk_st("R2 uncosted dropped");
    cmd_wr(7'h72, 1, 32'h0102_0304);
    pop_chk("R1 16-bit head");
    pop_chk("R1 32-bit head");
    pop_chk("R1 code 72 head");
    chk_st("R4 drained");

    // R3 fill to capacity, half-flag boundary
    for (int i = 0; i < 256; i++) begin
      cmd_wr(7'h11, (i % 2) == 1, 32'h5A00_0000 | i);
      if (i == 126 || i == 127) chk_st("R4 half boundary");
    end
    chk_st("R3 full");
    cmd_wr(7'h12, 1, 32'hFFFF_FFFF);
    chk_st("R3 overflow dropped");

    // R7 mode write leaves other fields
    bus_wr(10'h202, 0, 32'h0000_4000);
    m_mode = 2'd1;
    chk_st("R7 mode 1 via upper half");

    // R6 drain to half
    for (int i = 0; i < 128; i++) pop_chk("R3 full contents");
    chk_st("R6 count 128 no irq");
    pop_chk("R3 full contents");
    chk_st("R6 count 127 irq");
    while (sb.size() > 0) pop_chk("R3 full contents");

    bus_wr(10'h200, 1, 32'h8000_0000);
    m_mode = 2'd2;
    chk_st("R6 mode 2 empty irq");
    cmd_wr(7'h40, 0, 32'h0000_7777);
    chk_st("R6 mode 2 not empty");

    // R5 push and pop together
    begin
      logic [38:0] e;
      @(negedge clk);
      e = sb.pop_front();
      chk("R5 head before", {valid, cmd, param}, {1'b1, e});
      sb.push_back({7'h41, 32'h1234_5678});
      wr_en = 1; wr_addr = {1'b0, 7'h41, 2'b00}; wr_wide = 1; wr_data = 32'h1234_5678;
      pop = 1;
      @(negedge clk);
      wr_en = 0; pop = 0;
      chk_st("R5 count held");
    end
    pop_chk("R5 new head");
    @(negedge clk);
    pop = 1;
    @(negedge clk);
    pop = 0;
    chk_st("R5 pop on empty");

    // R8 busy
    exec_busy = 1;
    @(negedge clk);
    m_busy = 1;
    exec_busy = 0;
    chk_st("R8 busy follows exec");
    @(negedge clk);
    m_busy = 0;
    chk_st("R8 busy released");

    // R10 swap pending
    swap_req = 1;
    @(negedge clk);
    swap_req = 0; m_swap = 1;
    chk_st("R10 swap counted");
    chk("R10 valid stays low", {38'h0, valid}, 39'h0);
    swap_req = 1; swap_ack = 1;
    @(negedge clk);
    swap_req = 0; swap_ack = 0; m_swap = 0;
    chk_st("R10 ack wins");

    // R9 error and level bits
    err_set = 1; proj_set = 1;
    @(negedge clk);
    err_set = 0; proj_set = 0; m_err = 1; m_proj = 1;
    chk_st("R9 set");
    bus_wr(10'h200, 0, 32'h0000_FFFD);
    chk_st("R9 write 0 keeps");
    bus_wr(10'h200, 0, 32'h0000_0002);
    m_err = 0; m_proj = 0;
    chk_st("R9 write 1 clears");

    // R7 upper write of all ones sets only mode
    bus_wr(10'h202, 0, 32'h0000_FFFF);
    m_mode = 2'd3;
    chk_st("R7 mode 3 only");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule